// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers up to 25 asynchronous event lines into a sticky pending register and turns them into two level interrupt lines toward host processors. Each event line is synchronized, and only its low-to-high transition records a pending bit. Software clears pending bits by writing ones to them. A mask register stops chosen sources from reaching either host. A route register sends each source to one of the two host outputs.

Every register sits behind a small generic port: a write strobe, a two-bit register index, write data and combinational read data. The host outputs are levels built from the stored state. A host that samples them on a rising edge sees a new edge only after every unmasked pending source on that output has been cleared.

Top module: `irq_status_ctrl`

## Requirements
- R1: The pending register (index 0) holds one bit per source in bits 0 to 24. A bit set by an event stays set until it is cleared by a write.
- R2: A write to index 0 clears every pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value, so writing 0x1FFFFFF clears all pending events.
- R3: An event recorded on the same clock edge as a clearing write to its bit wins, and the bit stays set.
- R4: The mask register (index 1) blocks source i from both host outputs while bit i is 1. With the mask at 0x1FFFFFF both outputs are low.
- R5: The route register (index 2) sends source i to `irq_b` when bit i is 1 and to `irq_a` when it is 0. Each output is high exactly when some pending, unmasked source routed to it exists.
- R6: An event input first sampled high at clock edge k sets its pending bit at edge k+2 and not earlier. An input held high records one event only.
- R7: During and right after reset, the pending register reads 0, the mask reads 0x1FFFFFF, the route register reads 0, and both outputs are low.
- R8: Bits 25 to 31 of every register read as 0 and ignore writes. Index 3 reads as 0, and writes to it change nothing.
- R9: A write to index 1 or 2 takes effect on the next clock edge and reads back masked to 25 bits. Without a write, those registers hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 25 | Asynchronous event lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 pending, 1 mask, 2 route, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |
| irq_a | output | 1 | Interrupt toward the first host |
| irq_b | output | 1 | Interrupt toward the second host |

## Verification
The bench builds the block with its default of 25 sources on a 32-bit register port. This makes the full all-ones mask and clear values reachable, along with the reserved bits 25 to 31 and the unused index 3. Bit 20 routed to the second host and bit 0 left on the first host are both exercised. Directed sequences line up an event edge with a clearing write on the same clock. A pseudo-random phase then mixes event toggles with writes to every index.

// File: rtl/irqsc_pkg.sv
package irqsc_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_PEND  = 2'd0,
    RA_MASK  = 2'd1,
    RA_ROUTE = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;

  // Low n bits set: the implemented source bits.
  function automatic logic [REG_W-1:0] src_bits(input int n);
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i < n) v[i] = 1'b1;
    end
    return v;
  endfunction

  // Write-one-to-clear update; a new event overrides the clear.
  function automatic logic [REG_W-1:0] w1c_next(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] clr,
                                                input logic [REG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Any pending, unmasked source steered to the chosen host.
  function automatic logic any_routed(input logic [REG_W-1:0] pend,
                                      input logic [REG_W-1:0] mask,
                                      input logic [REG_W-1:0] route,
                                      input logic             to_b);
    logic [REG_W-1:0] sel;
    sel = to_b ? route : ~route;
    return |(pend & ~mask & sel);
  endfunction

endpackage

// File: rtl/irqsc_edge_sync.sv
module irqsc_edge_sync #(
  parameter int NUM_SRC = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic [NUM_SRC-1:0] rise
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= evt_in[i];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end

    assign rise[i] = sync_q & ~last_q;
  end

  // A source cannot report an edge on two consecutive cycles.
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise & $past(rise)) == '0)); // R6

endmodule

// File: rtl/irqsc_pending.sv
module irqsc_pending
  import irqsc_pkg::*;
#(
  parameter int NUM_SRC = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] pend_q
);

  localparam logic [REG_W-1:0] SRC_MASK = src_bits(NUM_SRC);

  logic [REG_W-1:0] pend_d;

  always_comb pend_d = w1c_next(pend_q, clr_vec, set_vec) & SRC_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0)); // R1

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0)); // R2

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(set_vec & SRC_MASK)) == $past(set_vec & SRC_MASK))); // R3

endmodule

// File: rtl/irqsc_cfg.sv
module irqsc_cfg
  import irqsc_pkg::*;
#(
  parameter int NUM_SRC = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic             route_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] route_q
);

  localparam logic [REG_W-1:0] SRC_MASK = src_bits(NUM_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= SRC_MASK;
      route_q <= '0;
    end else begin
      if (mask_we)  mask_q  <= wdata & SRC_MASK;
      if (route_we) route_q <= wdata & SRC_MASK;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q)); // R9

  AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !route_we |=> $stable(route_q)); // R9

endmodule

// File: rtl/irqsc_route.sv
module irqsc_route
  import irqsc_pkg::*;
(
  input  logic [REG_W-1:0] pend_q,
  input  logic [REG_W-1:0] mask_q,
  input  logic [REG_W-1:0] route_q,
  output logic             irq_a,
  output logic             irq_b
);

  always_comb begin
    irq_a = any_routed(pend_q, mask_q, route_q, 1'b0);
    irq_b = any_routed(pend_q, mask_q, route_q, 1'b1);
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqsc_pkg::*;
#(
  parameter int NUM_SRC = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq_a,
  output logic               irq_b
);

  localparam logic [REG_W-1:0] SRC_MASK = src_bits(NUM_SRC);

  logic [NUM_SRC-1:0] rise;
  logic [REG_W-1:0]   set_vec;
  logic [REG_W-1:0]   clr_vec;
  logic [REG_W-1:0]   pend_q;
  logic [REG_W-1:0]   mask_q;
  logic [REG_W-1:0]   route_q;
  logic               wr_pend;
  logic               wr_mask;
  logic               wr_route;

  always_comb begin
    wr_pend  = reg_we && (reg_addr_e'(reg_addr) == RA_PEND);
    wr_mask  = reg_we && (reg_addr_e'(reg_addr) == RA_MASK);
    wr_route = reg_we && (reg_addr_e'(reg_addr) == RA_ROUTE);
    clr_vec  = wr_pend ? (reg_wdata & SRC_MASK) : '0;
    set_vec  = '0;
    set_vec[NUM_SRC-1:0] = rise;
  end

  irqsc_edge_sync #(.NUM_SRC(NUM_SRC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_in (evt_in),
    .rise   (rise)
  );

  irqsc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pend_q  (pend_q)
  );

  irqsc_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_we  (wr_mask),
    .route_we (wr_route),
    .wdata    (reg_wdata),
    .mask_q   (mask_q),
    .route_q  (route_q)
  );

  irqsc_route u_route (
    .pend_q  (pend_q),
    .mask_q  (mask_q),
    .route_q (route_q),
    .irq_a   (irq_a),
    .irq_b   (irq_b)
  );

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_PEND:  reg_rdata = pend_q;
      RA_MASK:  reg_rdata = mask_q;
      RA_ROUTE: reg_rdata = route_q;
      default:  reg_rdata = '0;
    endcase
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == SRC_MASK) |-> (!irq_a && !irq_b)); // R4

endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;

  localparam int NS = 25;
  localparam logic [31:0] ALL = 32'h01FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0] evt = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_a;
  logic        irq_b;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  // Behavioural reference model
  logic [31:0] m_pend = '0;
  logic [31:0] m_mask = ALL;
  logic [31:0] m_route = '0;
  logic [NS-1:0] hist[$];

  initial begin
    hist.push_back('0); hist.push_back('0); hist.push_back('0);
  end

  always @(posedge clk) begin
    logic [NS-1:0] edge_now;
    logic [31:0] nxt;
    if (!rst_n) begin
      m_pend = '0; m_mask = ALL; m_route = '0;
      hist.delete();
      hist.push_back('0); hist.push_back('0); hist.push_back('0);
    end else begin
      hist.push_back(evt);
      while (hist.size() > 4) void'(hist.pop_front());
      // edge recorded now was sampled two edges ago
      edge_now = hist[1] & ~hist[0];
      nxt = m_pend;
      if (reg_we && reg_addr == 2'd0) begin
        for (int i = 0; i < NS; i++) if (reg_wdata[i]) nxt[i] = 1'b0;
      end
      for (int i = 0; i < NS; i++) if (edge_now[i]) nxt[i] = 1'b1;
      m_pend = nxt;
      if (reg_we && reg_addr == 2'd1) m_mask = reg_wdata & ALL;
      if (reg_we && reg_addr == 2'd2) m_route = reg_wdata & ALL;
    end
  end

  function automatic bit model_irq(bit to_b);
    for (int i = 0; i < NS; i++)
      if (m_pend[i] && !m_mask[i] && (m_route[i] == to_b)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_reg(logic [1:0] a);
    case (a)
      2'd0: return m_pend;
      2'd1: return m_mask;
      2'd2: return m_route;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison of both host lines
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 irq_a", {31'b0, irq_a}, {31'b0, model_irq(1'b0)});
      check("R5 irq_b", {31'b0, irq_b}, {31'b0, model_irq(1'b1)});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, model_reg(a));
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic pulse_evt(input int b);
    @(negedge clk); evt[b] = 1'b1;
    idle(3);
    evt[b] = 1'b0;
    idle(4);
  endtask

  initial begin
    logic [31:0] lfsr;
    // R7 reset values
    idle(3);
    rd_exp(2'd0, 32'h0, "R7 pending reset");
    rd_exp(2'd1, ALL, "R7 mask reset");
    rd_exp(2'd2, 32'h0, "R7 route reset");
    check("R7 irq_a reset", {31'b0, irq_a}, 32'h0);
    check("R7 irq_b reset", {31'b0, irq_b}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    rd_exp(2'd1, ALL, "R7 mask after reset");

    // R4: event while fully masked leaves outputs low but pending set
    pulse_evt(2);
    check("R4 masked irq_a", {31'b0, irq_a}, 32'h0);
    rd_exp(2'd0, 32'h4, "R1 pending while masked");

    // R9 unmask all
    wr(2'd1, 32'h0);
    rd_exp(2'd1, 32'h0, "R9 mask readback");
    check("R5 irq_a after unmask", {31'b0, irq_a}, 32'h1);

    // R6 timing: sampled high at edge k, set after edge k+2
    wr(2'd0, ALL);
    rd_exp(2'd0, 32'h0, "R4 clear all");
    @(negedge clk); evt[9] = 1'b1;
    @(negedge clk); rd_exp(2'd0, 32'h0, "R6 not yet after k");
    @(negedge clk); rd_exp(2'd0, 32'h0, "R6 not yet after k+1");
    @(negedge clk); rd_exp(2'd0, 32'h200, "R6 set after k+2");
    // level held: clear, stays clear
    wr(2'd0, 32'h200);
    idle(5);
    rd_exp(2'd0, 32'h0, "R6 held level no second event");
    evt[9] = 1'b0;
    idle(3);

    // R1 / R2 partial clear
    pulse_evt(0); pulse_evt(3); pulse_evt(7);
    rd_exp(2'd0, 32'h89, "R1 sticky bits");
    wr(2'd0, 32'h8);
    rd_exp(2'd0, 32'h81, "R2 clear one bit");
    wr(2'd0, 32'h0);
    rd_exp(2'd0, 32'h81, "R2 zero write no change");

    // R3 collision: bit 5 already set, new edge lands on the clearing edge
    pulse_evt(5);
    @(negedge clk); evt[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h20;
    @(negedge clk); reg_we = 1'b0;
    rd_exp(2'd0, 32'h81 | 32'h20, "R3 event wins over clear");
    evt[5] = 1'b0;
    wr(2'd0, 32'h20);
    rd_exp(2'd0, 32'h81, "R2 clear without event");

    // R5 routing: bit 20 to second host
    wr(2'd0, ALL);
    wr(2'd2, 32'h0010_0000);
    rd_exp(2'd2, 32'h0010_0000, "R9 route readback");
    pulse_evt(20);
    check("R5 bit20 on irq_b", {31'b0, irq_b}, 32'h1);
    check("R5 bit20 not on irq_a", {31'b0, irq_a}, 32'h0);
    pulse_evt(0);
    check("R5 bit0 on irq_a", {31'b0, irq_a}, 32'h1);
    wr(2'd1, 32'h1);
    check("R4 bit0 masked", {31'b0, irq_a}, 32'h0);
    check("R4 bit20 still up", {31'b0, irq_b}, 32'h1);
    wr(2'd1, 32'hFFFF_FFFF);
    rd_exp(2'd1, ALL, "R8 upper mask bits read zero");
    check("R4 all masked irq_b", {31'b0, irq_b}, 32'h0);

    // R8 unused index and reserved bits
    wr(2'd3, 32'hFFFF_FFFF);
    rd_exp(2'd3, 32'h0, "R8 index 3 reads zero");
    rd_exp(2'd2, 32'h0010_0000, "R8 index 3 write no effect on route");
    rd_exp(2'd1, ALL, "R8 index 3 write no effect on mask");
    rd(2'd0, "R8 index 3 write no effect on pending");
    wr(2'd2, 32'hFE00_0000);
    rd_exp(2'd2, 32'h0, "R8 reserved route bits ignored");

    // Mixed pseudo-random phase
    wr(2'd1, 32'h0);
    lfsr = 32'hACE1_2345;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      evt = evt ^ (lfsr[NS-1:0] & {lfsr[7:0], lfsr[31:15]});
      reg_we = (c % 7 == 3);
      reg_addr = lfsr[4:3];
      reg_wdata = {lfsr[15:0], lfsr[31:16]};
      if (c % 11 == 0) begin
        logic [1:0] sv;
        sv = reg_addr;
        reg_we = 1'b0;
        rd(lfsr[9:8], "R1 random readback");
        reg_addr = sv;
      end
    end
    @(negedge clk); reg_we = 1'b0;
    idle(4);
    rd(2'd0, "R2 final pending");
    rd(2'd1, "R9 final mask");
    rd(2'd2, "R9 final route");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule